// File: doc/BRIEF.md
# Radix-2 Booth Sequential Multiplier

This block multiplies two signed two's-complement operands of `N` bits (default 8) and returns their signed product of `2N` bits. It takes one step per clock and finishes in `N` steps. It keeps one working register of `2N+1` bits. The top `N` bits are the running accumulator. The next `N` bits start as the multiplier and are consumed one bit per step. The lowest bit holds the multiplier bit that was last shifted out, and it is zero at the start.

On each step the block looks at two bits: the lowest multiplier bit and the appended bit to its right. The pair `10` begins a run of ones, so the multiplicand is subtracted from the accumulator. The pair `01` ends a run of ones, so the multiplicand is added. The pairs `00` and `11` change nothing. After this optional add or subtract, the whole register shifts right by one place, copying the sign bit. The add and subtract are computed one bit wider than the accumulator, so the most negative multiplicand cannot overflow before the shift.

A client pulses `start` with both operands present while the block is idle. `busy` stays high while the steps run. `done` then pulses for one cycle, and the product is valid in that same cycle. The product is held until the next multiplication completes.

Top module: `booth_seq_mult`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` sampled high at a rising edge while `busy` is low is accepted. `busy` is then high for exactly `N` cycles, starting with the cycle after that edge.
- R3: In the cycle after the last busy cycle, `done` is 1 and `busy` is 0. In the cycle after that, `done` is 0 again.
- R4: In the cycle in which `done` is 1, `product` equals the signed product of the two operands captured at the accepted start. The operands are read as two's complement and the product as a signed `2N`-bit value.
- R5: The step decisions follow Booth recoding of the pair (current bit, bit to its right), with the appended bit starting at 0. `10` subtracts, `01` adds, `00`/`11` only shift. This is checked through a multiplier of all ones (one subtract only), zero, one, and alternating bit patterns.
- R6: Multiplying with the most negative operand value gives the exact result, for example (-128)x(-128)=16384 and (-128)x(-1)=128 at N=8.
- R7: A `start` while `busy` is high is ignored. Operand changes while busy are also ignored. The running result and its completion cycle are unchanged, and no second `done` follows.
- R8: `product` changes only in a cycle in which `done` is 1. Outside those cycles it keeps its last value, including while a new multiplication is running.
- R9: At N=4 the block gives 2x7 = 8'b0000_1110 and 2x(-3) = 8'b1111_1010, and gives the exact signed product for every 4-bit operand pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| mcand_in | input | N | Signed multiplicand, read at an accepted start |
| mplier_in | input | N | Signed multiplier, read at an accepted start |
| busy | output | 1 | Steps are in progress |
| done | output | 1 | One-cycle pulse: product is valid |
| product | output | 2N | Signed product, held until the next completion |

## Verification
The start edge counts as cycle 0. `busy` is due in cycles 1 through N, and `done` and the new `product` are due in cycle N+1. `done` is low again in cycle N+2. Each scenario task drives its inputs on the falling edge. It then counts falling edges from the start edge and samples `busy`, `done` and `product` only at those counted points. One task checks every intermediate cycle, and another checks that a second start issued mid-run neither shifts the completion cycle nor produces a further `done` within the following N+2 cycles.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        OP_KEEP = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } step_op_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic     cur_bit,
    input  logic     right_bit,
    output step_op_e op
);
    always_comb begin
        unique case ({cur_bit, right_bit})
            2'b10:   op = OP_SUB;
            2'b01:   op = OP_ADD;
            default: op = OP_KEEP;
        endcase
    end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] mcand,
    input  step_op_e     op,
    output logic [W:0]   sum
);
    logic [W:0] acc_x;
    logic [W:0] mc_x;

    always_comb begin
        acc_x = {acc[W-1], acc};
        mc_x  = {mcand[W-1], mcand};
        unique case (op)
            OP_ADD:  sum = acc_x + mc_x;
            OP_SUB:  sum = acc_x - mc_x;
            default: sum = acc_x;
        endcase
    end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int N  = 8,
    parameter int CW = 4
) (
    input  phase_e          phase_q,
    input  logic [CW-1:0]   cnt_q,
    input  logic            start,
    output phase_e          phase_d,
    output logic [CW-1:0]   cnt_d,
    output logic            load,
    output logic            step,
    output logic            last
);
    localparam logic [CW-1:0] LAST_CNT = CW'(N - 1);

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        load    = 1'b0;
        step    = 1'b0;
        last    = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    phase_d = PH_RUN;
                    cnt_d   = '0;
                end
            end
            PH_RUN: begin
                step = 1'b1;
                last = (cnt_q == LAST_CNT);
                if (last) begin
                    phase_d = PH_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic signed [N-1:0]   mcand_in,
    input  logic signed [N-1:0]   mplier_in,
    output logic                  busy,
    output logic                  done,
    output logic signed [2*N-1:0] product
);
    localparam int CW = $clog2(N + 1);
    localparam int PW = 2 * N;

    typedef struct packed {
        phase_e          phase;
        logic [CW-1:0]   cnt;
        logic [N-1:0]    acc;
        logic [N-1:0]    mq;
        logic            xb;
        logic [N-1:0]    mc;
        logic            done;
        logic [PW-1:0]   res;
    } state_t;

    state_t s_q, s_d;

    phase_e        phase_n;
    logic [CW-1:0] cnt_n;
    logic          load, step, last;
    step_op_e      op;
    logic [N:0]    sum;

    booth_ctrl #(.N(N), .CW(CW)) u_ctrl (
        .phase_q (s_q.phase),
        .cnt_q   (s_q.cnt),
        .start   (start),
        .phase_d (phase_n),
        .cnt_d   (cnt_n),
        .load    (load),
        .step    (step),
        .last    (last)
    );

    booth_recode u_recode (
        .cur_bit   (s_q.mq[0]),
        .right_bit (s_q.xb),
        .op        (op)
    );

    booth_addsub #(.W(N)) u_addsub (
        .acc   (s_q.acc),
        .mcand (s_q.mc),
        .op    (op),
        .sum   (sum)
    );

    always_comb begin
        s_d       = s_q;
        s_d.phase = phase_n;
        s_d.cnt   = cnt_n;
        s_d.done  = 1'b0;
        if (load) begin
            s_d.acc = '0;
            s_d.mq  = mplier_in;
            s_d.xb  = 1'b0;
            s_d.mc  = mcand_in;
        end
        if (step) begin
            s_d.acc = sum[N:1];
            s_d.mq  = {sum[0], s_q.mq[N-1:1]};
            s_d.xb  = s_q.mq[0];
            if (last) begin
                s_d.done = 1'b1;
                s_d.res  = {sum[N:1], sum[0], s_q.mq[N-1:1]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase <= PH_IDLE;
            s_q.cnt   <= '0;
            s_q.acc   <= '0;
            s_q.mq    <= '0;
            s_q.xb    <= 1'b0;
            s_q.mc    <= '0;
            s_q.done  <= 1'b0;
            s_q.res   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = (s_q.phase == PH_RUN);
    assign done    = s_q.done;
    assign product = s_q.res;

endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [2*N-1:0] product
);
    int run_len;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && product == '0));

    // R2
    a_r2_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R2
    a_r2_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == N));

    // R3
    a_r3_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R3
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    a_r3_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    a_r8_product_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(product));

endmodule

bind booth_seq_mult booth_seq_mult_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/tb_booth_seq_mult.sv
`timescale 1ns/1ps
module tb_booth_seq_mult;
    localparam int N  = 8;
    localparam int M  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic                  start = 1'b0;
    logic signed [N-1:0]   a = '0;
    logic signed [N-1:0]   b = '0;
    logic                  busy, done;
    logic signed [2*N-1:0] product;

    logic                  start4 = 1'b0;
    logic signed [M-1:0]   a4 = '0;
    logic signed [M-1:0]   b4 = '0;
    logic                  busy4, done4;
    logic signed [2*M-1:0] product4;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    booth_seq_mult #(.N(N)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mcand_in(a), .mplier_in(b),
        .busy(busy), .done(done), .product(product)
    );

    booth_seq_mult #(.N(M)) dut_n4 (
        .clk(clk), .rst_n(rst_n), .start(start4),
        .mcand_in(a4), .mplier_in(b4),
        .busy(busy4), .done(done4), .product(product4)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic signed [2*N-1:0] ref8(input logic signed [N-1:0] x,
                                                   input logic signed [N-1:0] y);
        int p;
        p = int'(x) * int'(y);
        return (2*N)'(p);
    endfunction

    // Starts at a falling edge; returns at the falling edge of cycle N+1.
    task automatic run8(input logic signed [N-1:0] x, input logic signed [N-1:0] y,
                        output logic d, output logic bz, output logic signed [2*N-1:0] p);
        a = x; b = y; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (N) @(negedge clk);
        d = done; bz = busy; p = product;
    endtask

    task automatic mul8(input logic signed [N-1:0] x, input logic signed [N-1:0] y,
                        input string req);
        logic d, bz;
        logic signed [2*N-1:0] p;
        run8(x, y, d, bz, p);
        check(d == 1'b1, req, "done at cycle N+1", d, 1);
        check(p == ref8(x, y), req, "product", p, ref8(x, y));
    endtask

    task automatic t_reset;
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(done == 1'b0, "R1", "done after reset", done, 0);
        check(product == '0, "R1", "product after reset", product, 0);
    endtask

    task automatic t_timing;
        a = 8'sd5; b = -8'sd7; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= N; k++) begin
            check(busy == 1'b1, "R2", "busy during steps", busy, 1);
            check(done == 1'b0, "R3", "done early", done, 0);
            @(negedge clk);
        end
        check(busy == 1'b0, "R3", "busy at cycle N+1", busy, 0);
        check(done == 1'b1, "R3", "done at cycle N+1", done, 1);
        check(product == -16'sd35, "R4", "5 x -7", product, -35);
        @(negedge clk);
        check(done == 1'b0, "R3", "done at cycle N+2", done, 0);
    endtask

    task automatic t_recode;
        mul8(8'sd37, -8'sd1, "R5");
        mul8(8'sd37, 8'sd0, "R5");
        mul8(8'sd37, 8'sd1, "R5");
        mul8(-8'sd37, 8'sh55, "R5");
        mul8(8'sd99, -8'sd86, "R5");
        mul8(-8'sd1, 8'sd127, "R5");
    endtask

    task automatic t_extreme;
        mul8(-8'sd128, -8'sd128, "R6");
        mul8(-8'sd128, -8'sd1, "R6");
        mul8(-8'sd128, 8'sd127, "R6");
        mul8(8'sd127, -8'sd128, "R6");
        mul8(8'sd127, 8'sd127, "R6");
    endtask

    task automatic t_ignore;
        logic signed [2*N-1:0] prev;
        prev = product;
        a = -8'sd19; b = 8'sd23; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(product == prev, "R8", "product held while busy", product, prev);
        @(negedge clk);
        a = 8'sd3; b = 8'sd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        a = 8'sd100; b = -8'sd100;
        repeat (N - 2) @(negedge clk);
        check(done == 1'b1, "R7", "done cycle unchanged", done, 1);
        check(product == -16'sd437, "R7", "first operands kept", product, -437);
        prev = product;
        for (int k = 0; k < N + 2; k++) begin
            @(negedge clk);
            check(done == 1'b0 && busy == 1'b0, "R7", "no second run", {busy, done}, 0);
            check(product == prev, "R8", "product held idle", product, prev);
        end
    endtask

    task automatic t_sweep;
        for (int i = 0; i < 12; i++) begin
            for (int j = 0; j < 12; j++) begin
                logic signed [N-1:0] cv [12];
                cv = '{-8'sd128, -8'sd127, -8'sd65, -8'sd64, -8'sd1, 8'sd0,
                       8'sd1, 8'sd2, 8'sd63, 8'sd64, 8'sd126, 8'sd127};
                mul8(cv[i], cv[j], "R4");
            end
        end
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 32; j++) begin
                mul8(N'(i), N'(j * 8 + (i & 7)), "R4");
            end
        end
    endtask

    task automatic mul4(input logic signed [M-1:0] x, input logic signed [M-1:0] y,
                        output logic d, output logic signed [2*M-1:0] p);
        a4 = x; b4 = y; start4 = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start4 = 1'b0;
        repeat (M) @(negedge clk);
        d = done4; p = product4;
    endtask

    task automatic t_n4;
        logic d;
        logic signed [2*M-1:0] p;
        mul4(4'sd2, 4'sd7, d, p);
        check(d == 1'b1 && p == 8'b0000_1110, "R9", "2 x 7", p, 14);
        mul4(4'sd2, -4'sd3, d, p);
        check(d == 1'b1 && p == 8'b1111_1010, "R9", "2 x -3", p, -6);
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                logic signed [M-1:0] x, y;
                logic signed [2*M-1:0] e;
                x = M'(i); y = M'(j);
                e = (2*M)'(int'(x) * int'(y));
                mul4(x, y, d, p);
                check(d == 1'b1 && p == e, "R9", "4-bit pair", p, e);
            end
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1", "outputs in reset", {busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timing();
        t_recode();
        t_extreme();
        t_ignore();
        t_sweep();
        t_n4();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule